// File: doc/BRIEF.md
# Multi-Counter Output Resequencer Release

This block decides, at one switch output, which waiting cell may leave next. Each cell entering the output carries the number of the input it came from, up to K hashed counter indices with a sequence value for each, a use mask that says which of those K slots are live, and a small tag that names its descriptor. For every input the block keeps a table of next-expected values, one per counter index. Arriving cells are held in a pending store until every live counter they carry matches its expected value. When a cell departs, each of those counters moves forward by one.

Two recovery paths sit on top of the ordering rule. A cell may wait for a missing predecessor that never comes. When the oldest waiting cell has waited a set number of slots and nothing can leave, its counters are moved forward to its own values, so it and later cells can flow. A late cell whose values are already behind the tables is discarded. A late copy of a cell that was rebuilt elsewhere is the usual case.

Both edges are valid/ready streams. An arrival is taken on a cycle where `in_valid` and `in_ready` are both high, and `in_ready` is low exactly while the store is full. A departure is offered on `out_valid`. It completes on a cycle where `out_ready` is also high. While `out_ready` is low, the offered cell stays the same. `stale_drop` and `loss_skip` are single-cycle status pulses.

Top module: `rsq_release`

## Requirements
- R1: After reset, `out_valid`, `stale_drop` and `loss_skip` are 0, `in_ready` is 1, and every expected value of every input is 0.
- R2: A held cell is offered on the output only when, for each bit k set in its use mask, the sequence value in field k of `in_seq` (bits k*10 and up) equals the expected value of counter index field k of `in_idx` (bits k*6 and up) in its input's table. Slots with a clear mask bit are ignored. An accepted cell is offered at the earliest in the cycle after it was taken.
- R3: When a cell departs, the expected value of each counter named by its live slots becomes that cell's value plus one, modulo 1024. Other counters keep their values.
- R4: At most one cell leaves per cycle. Among eligible cells, the one accepted earliest is offered.
- R5: When no cell is eligible and the oldest held cell has waited at least TIMEOUT cycles since it was accepted, and none of its values is behind, its live counters are set to its own values. `loss_skip` pulses in the next cycle, and the cell is offered in that same next cycle.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_src` and `out_tag` do not change.
- R7: An arriving cell with any live value behind the expected one is accepted and discarded. Behind means that bit 9 of (value − expected) mod 1024 is set. `stale_drop` pulses in the next cycle and nothing is offered for it.
- R8: The store holds 16 cells. With 16 held, `in_ready` is 0 and an offered cell is not taken.
- R9: Each input has its own table. Departures from one input do not change the expected values of another input.
- R10: When the timeout of R5 falls on an oldest cell that has a value behind its expected one, that cell is removed without departing, and `stale_drop` pulses in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Arrival offered |
| in_ready | output | 1 | Store has a free entry |
| in_src | input | 2 | Input number of the arriving cell |
| in_use | input | 4 | Live mask of the K counter slots |
| in_idx | input | 24 | K counter indices, 6 bits each, slot 0 lowest |
| in_seq | input | 40 | K sequence values, 10 bits each, slot 0 lowest |
| in_tag | input | 8 | Descriptor tag |
| out_valid | output | 1 | Departure offered |
| out_ready | input | 1 | Downstream takes the departure |
| out_src | output | 2 | Input number of the departing cell |
| out_tag | output | 8 | Tag of the departing cell |
| stale_drop | output | 1 | A stale cell was discarded in the previous cycle |
| loss_skip | output | 1 | Counters were skipped over a lost cell in the previous cycle |

## Verification
The assertions assume that the counter indices within one cell are distinct. They also assume that no two held cells from the same input carry the same value on a shared counter, as an in-order sender produces. The stimulus builds each cell's indices as consecutive values in a small window. Values are taken from a per-input sender counter that steps once per use, so both assumptions hold. Arrivals are shuffled only within groups of four, and missing cells always come well inside the timeout in the random phase. Timeouts and stale cells come only from the directed cases.

// File: rtl/rsq_pkg.sv
package rsq_pkg;
  typedef enum logic [1:0] {
    UPD_NONE   = 2'd0,
    UPD_DEPART = 2'd1,
    UPD_SKIP   = 2'd2
  } upd_kind_e;
endpackage

// File: rtl/rsq_ctr_table.sv
// Expected-value tables, one row of N_CTR counters per input.
// N_IN and N_CTR are powers of two so {src,idx} forms the address.
module rsq_ctr_table
  import rsq_pkg::*;
#(
  parameter int N_IN  = 4,
  parameter int N_CTR = 64,
  parameter int K     = 4,
  parameter int SEQ_W = 10,
  localparam int SRC_W = $clog2(N_IN),
  localparam int IDX_W = $clog2(N_CTR),
  localparam int ENT   = N_IN * N_CTR
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  upd_kind_e              upd_kind,
  input  logic [SRC_W-1:0]       upd_src,
  input  logic [K-1:0]           upd_use,
  input  logic [K*IDX_W-1:0]     upd_idx,
  input  logic [K*SEQ_W-1:0]     upd_seq,
  output logic [SEQ_W-1:0]       exp_o [ENT]
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int a = 0; a < ENT; a++) exp_o[a] <= '0;
    end else if (upd_kind != UPD_NONE) begin
      for (int k = 0; k < K; k++) begin
        if (upd_use[k]) begin
          exp_o[{upd_src, upd_idx[k*IDX_W +: IDX_W]}] <=
            (upd_kind == UPD_DEPART) ? upd_seq[k*SEQ_W +: SEQ_W] + 1'b1
                                     : upd_seq[k*SEQ_W +: SEQ_W];
        end
      end
    end
  end
endmodule

// File: rtl/rsq_oldest.sv
// Picks the candidate with the largest age.
module rsq_oldest #(
  parameter int N    = 16,
  parameter int TS_W = 16,
  localparam int SEL_W = $clog2(N)
) (
  input  logic [N-1:0]      cand,
  input  logic [N*TS_W-1:0] ages,
  output logic              found,
  output logic [SEL_W-1:0]  sel
);
  logic [TS_W-1:0] best;
  always_comb begin
    found = 1'b0;
    sel   = '0;
    best  = '0;
    for (int i = 0; i < N; i++) begin
      if (cand[i] && (!found || ages[i*TS_W +: TS_W] > best)) begin
        found = 1'b1;
        sel   = SEL_W'(i);
        best  = ages[i*TS_W +: TS_W];
      end
    end
  end
endmodule

// File: rtl/rsq_release.sv
module rsq_release
  import rsq_pkg::*;
#(
  parameter int N_IN    = 4,
  parameter int N_CTR   = 64,
  parameter int K       = 4,
  parameter int SEQ_W   = 10,
  parameter int DEPTH   = 16,
  parameter int TAG_W   = 8,
  parameter int TS_W    = 16,
  parameter int TIMEOUT = 64,
  localparam int SRC_W  = $clog2(N_IN),
  localparam int IDX_W  = $clog2(N_CTR),
  localparam int SLOT_W = $clog2(DEPTH),
  localparam int ENT    = N_IN * N_CTR
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [SRC_W-1:0]   in_src,
  input  logic [K-1:0]       in_use,
  input  logic [K*IDX_W-1:0] in_idx,
  input  logic [K*SEQ_W-1:0] in_seq,
  input  logic [TAG_W-1:0]   in_tag,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [SRC_W-1:0]   out_src,
  output logic [TAG_W-1:0]   out_tag,
  output logic               stale_drop,
  output logic               loss_skip
);
  localparam logic [TS_W-1:0] TMO = TS_W'(TIMEOUT);

  // pending store
  logic [DEPTH-1:0]   vld;
  logic [SRC_W-1:0]   e_src [DEPTH];
  logic [K-1:0]       e_use [DEPTH];
  logic [K*IDX_W-1:0] e_idx [DEPTH];
  logic [K*SEQ_W-1:0] e_seq [DEPTH];
  logic [TAG_W-1:0]   e_tag [DEPTH];
  logic [TS_W-1:0]    e_ts  [DEPTH];
  logic [TS_W-1:0]    now;

  logic [SEQ_W-1:0]   exp_tbl [ENT];
  logic [DEPTH-1:0]   elig, stale;
  logic [DEPTH*TS_W-1:0] ages;

  // per-entry order test against the tables
  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic el, st;
    always_comb begin
      el = 1'b1;
      st = 1'b0;
      for (int k = 0; k < K; k++) begin
        logic [SEQ_W-1:0] d;
        d = e_seq[g][k*SEQ_W +: SEQ_W] - exp_tbl[{e_src[g], e_idx[g][k*IDX_W +: IDX_W]}];
        if (e_use[g][k]) begin
          if (d != '0)      el = 1'b0;
          if (d[SEQ_W-1])   st = 1'b1;
        end
      end
    end
    assign elig[g]  = el & vld[g];
    assign stale[g] = st;
    assign ages[g*TS_W +: TS_W] = now - e_ts[g];
  end

  // arrival stale test
  logic in_stale;
  always_comb begin
    in_stale = 1'b0;
    for (int k = 0; k < K; k++) begin
      logic [SEQ_W-1:0] d;
      d = in_seq[k*SEQ_W +: SEQ_W] - exp_tbl[{in_src, in_idx[k*IDX_W +: IDX_W]}];
      if (in_use[k] && d[SEQ_W-1]) in_stale = 1'b1;
    end
  end

  // pickers: oldest eligible for departure, oldest held for timeout
  logic              dep_found, old_found;
  logic [SLOT_W-1:0] dep_sel, old_sel;

  rsq_oldest #(.N(DEPTH), .TS_W(TS_W)) u_pick_dep (
    .cand(elig), .ages(ages), .found(dep_found), .sel(dep_sel));
  rsq_oldest #(.N(DEPTH), .TS_W(TS_W)) u_pick_old (
    .cand(vld), .ages(ages), .found(old_found), .sel(old_sel));

  // free slot, lowest index
  logic [SLOT_W-1:0] free_sel;
  always_comb begin
    free_sel = '0;
    for (int i = DEPTH - 1; i >= 0; i--) if (!vld[i]) free_sel = SLOT_W'(i);
  end

  assign in_ready  = ~&vld;
  assign out_valid = dep_found;
  assign out_src   = e_src[dep_sel];
  assign out_tag   = e_tag[dep_sel];

  logic depart, tmo_go, tmo_stale, acc;
  assign depart    = out_valid && out_ready;
  assign tmo_go    = !dep_found && old_found && (ages[old_sel*TS_W +: TS_W] >= TMO);
  assign tmo_stale = stale[old_sel];
  assign acc       = in_valid && in_ready;

  upd_kind_e         upd_kind;
  logic [SLOT_W-1:0] upd_sel;
  always_comb begin
    upd_kind = UPD_NONE;
    if (depart)                     upd_kind = UPD_DEPART;
    else if (tmo_go && !tmo_stale)  upd_kind = UPD_SKIP;
    upd_sel = (upd_kind == UPD_DEPART) ? dep_sel : old_sel;
  end

  rsq_ctr_table #(.N_IN(N_IN), .N_CTR(N_CTR), .K(K), .SEQ_W(SEQ_W)) u_tbl (
    .clk(clk), .rst_n(rst_n), .upd_kind(upd_kind),
    .upd_src(e_src[upd_sel]), .upd_use(e_use[upd_sel]),
    .upd_idx(e_idx[upd_sel]), .upd_seq(e_seq[upd_sel]), .exp_o(exp_tbl));

  // control state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld        <= '0;
      now        <= '0;
      stale_drop <= 1'b0;
      loss_skip  <= 1'b0;
    end else begin
      now        <= now + 1'b1;
      stale_drop <= (acc && in_stale) || (tmo_go && tmo_stale);
      loss_skip  <= tmo_go && !tmo_stale;
      if (depart)                vld[dep_sel]  <= 1'b0;
      if (tmo_go && tmo_stale)   vld[old_sel]  <= 1'b0;
      if (acc && !in_stale)      vld[free_sel] <= 1'b1;
    end
  end

  // descriptor fields, no reset needed
  always_ff @(posedge clk) begin
    if (acc && !in_stale) begin
      e_src[free_sel] <= in_src;
      e_use[free_sel] <= in_use;
      e_idx[free_sel] <= in_idx;
      e_seq[free_sel] <= in_seq;
      e_tag[free_sel] <= in_tag;
      e_ts[free_sel]  <= now;
    end
  end
endmodule

// File: rtl/rsq_release_chk.sv
module rsq_release_chk #(
  parameter int DEPTH = 16,
  parameter int SRC_W = 2,
  parameter int TAG_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [SRC_W-1:0] out_src,
  input logic [TAG_W-1:0] out_tag,
  input logic             loss_skip,
  input logic [DEPTH-1:0] vld
);
  // R8: a full store refuses arrivals
  a_r8_full_refuse: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(vld) == DEPTH) |-> !in_ready);

  // R6: an offered cell is held steady under back-pressure
  a_r6_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_tag) && $stable(out_src)));

  // R5: a loss skip only follows a cycle with nothing offered
  a_r5_lost_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    loss_skip |-> $past(!out_valid));

  // R4: one departure frees exactly one entry
  a_r4_one_leave: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !(in_valid && in_ready)) |=>
      ($countones(vld) == $past($countones(vld)) - 1));
endmodule

bind rsq_release rsq_release_chk #(.DEPTH(DEPTH), .SRC_W(SRC_W), .TAG_W(TAG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_src(out_src),
  .out_tag(out_tag), .loss_skip(loss_skip), .vld(vld));

// File: tb/tb_rsq_release.sv
module tb_rsq_release;
  localparam int TMO = 64;
  localparam int NR  = 200;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b1;
  logic [1:0] in_src = '0;
  logic [3:0] in_use = '0;
  logic [23:0] in_idx = '0;
  logic [39:0] in_seq = '0;
  logic [7:0] in_tag = '0;
  logic in_ready, out_valid, stale_drop, loss_skip;
  logic [1:0] out_src;
  logic [7:0] out_tag;

  always #5 clk = ~clk;

  rsq_release #(.TIMEOUT(TMO)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_src(in_src), .in_use(in_use), .in_idx(in_idx), .in_seq(in_seq),
    .in_tag(in_tag), .out_valid(out_valid), .out_ready(out_ready),
    .out_src(out_src), .out_tag(out_tag), .stale_drop(stale_drop),
    .loss_skip(loss_skip));

  int n_chk = 0, n_err = 0;
  int drop_cnt = 0, lost_cnt = 0;
  int dep_q[$], exp_q[$];
  bit rnd_mode = 1'b0;
  int g_src [NR];
  int g_use [NR];
  int g_idx [NR][4];
  int g_seq [NR][4];
  int bexp [4][64];
  int gctr [4][64];

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // monitor, sampled at the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (stale_drop) drop_cnt++;
      if (loss_skip)  lost_cnt++;
      if (out_valid && out_ready) begin
        dep_q.push_back(int'(out_tag));
        if (rnd_mode) begin
          int t;
          t = int'(out_tag);
          check(int'(out_src) == g_src[t], "R9 source", int'(out_src), g_src[t]);
          for (int k = 0; k < 4; k++)
            if (g_use[t][k] != 0)
              check(g_seq[t][k] == bexp[g_src[t]][g_idx[t][k]], "R2/R3 order",
                    g_seq[t][k], bexp[g_src[t]][g_idx[t][k]]);
          for (int k = 0; k < 4; k++)
            if (g_use[t][k] != 0)
              bexp[g_src[t]][g_idx[t][k]] = (bexp[g_src[t]][g_idx[t][k]] + 1) % 1024;
        end
      end
    end
  end

  always @(posedge clk) begin
    #1;
    if (rnd_mode) out_ready = ($urandom % 4) != 0;
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    dep_q.delete();
    exp_q.delete();
  endtask

  task automatic set_ready(input logic v);
    @(posedge clk);
    #1 out_ready = v;
  endtask

  task automatic send(input int src, input int u, input int i0, input int i1,
                      input int i2, input int i3, input int s0, input int s1,
                      input int s2, input int s3, input int tag);
    @(negedge clk);
    in_src = 2'(src);
    in_use = 4'(u);
    in_idx = {6'(i3), 6'(i2), 6'(i1), 6'(i0)};
    in_seq = {10'(s3), 10'(s2), 10'(s1), 10'(s0)};
    in_tag = 8'(tag);
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic send1(input int src, input int idx, input int sq, input int tag);
    send(src, 1, idx, 63, 63, 63, sq, 0, 0, 0, tag);
  endtask

  task automatic check_deps(input string req);
    check(dep_q.size() == exp_q.size(), req, dep_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < dep_q.size(); i++)
      check(dep_q[i] == exp_q[i], req, dep_q[i], exp_q[i]);
    dep_q.delete();
    exp_q.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    int d0, l0, n;
    void'($urandom(32'd1234));
    do_reset();
    @(negedge clk);
    // R1 reset state
    check(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
    check(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
    check(stale_drop == 1'b0 && loss_skip == 1'b0, "R1 pulses", stale_drop, 0);

    // R2: zero expected, first cell goes at once
    send1(0, 1, 0, 10);
    @(negedge clk);
    check(out_valid && out_tag == 8'd10, "R2 in-order offer", out_tag, 10);
    send1(0, 1, 1, 11);
    repeat (3) @(negedge clk);
    exp_q = '{10, 11};
    check_deps("R3 advance");

    // R2 out of order on one counter
    send1(0, 5, 1, 20);
    @(negedge clk);
    check(!out_valid, "R2 hold gap", out_valid, 0);
    send1(0, 5, 0, 21);
    repeat (4) @(negedge clk);
    exp_q = '{21, 20};
    check_deps("R2 reorder");

    // R2 all live counters must match
    send(0, 3, 3, 4, 0, 0, 0, 1, 0, 0, 30);
    @(negedge clk);
    check(!out_valid, "R2 multi hold", out_valid, 0);
    send1(0, 4, 0, 31);
    repeat (4) @(negedge clk);
    exp_q = '{31, 30};
    check_deps("R2 multi release");

    // R2 unused slot ignored
    send(0, 1, 6, 7, 8, 9, 0, 55, 77, 99, 32);
    repeat (3) @(negedge clk);
    exp_q = '{32};
    check_deps("R2 mask");

    // R4/R6/R9 priority and hold
    set_ready(1'b0);
    send1(1, 9, 0, 40);
    send1(1, 8, 0, 41);
    send1(2, 9, 0, 42);
    @(negedge clk);
    check(out_valid && out_tag == 8'd40, "R4 oldest first", out_tag, 40);
    repeat (3) @(negedge clk);
    check(out_valid && out_tag == 8'd40 && out_src == 2'd1, "R6 hold", out_tag, 40);
    set_ready(1'b1);
    repeat (5) @(negedge clk);
    exp_q = '{40, 41, 42};
    check_deps("R4/R9 drain");

    // R8 full store
    do_reset();
    set_ready(1'b0);
    for (int k = 0; k < 16; k++) send1(0, 10, k, 50 + k);
    @(negedge clk);
    check(in_ready == 1'b0, "R8 full", in_ready, 0);
    in_src = 2'd3; in_use = 4'd1; in_idx = '0; in_seq = '0; in_tag = 8'd99;
    in_valid = 1'b1;
    repeat (2) @(negedge clk);
    in_valid = 1'b0;
    set_ready(1'b1);
    repeat (22) @(negedge clk);
    for (int k = 0; k < 16; k++) exp_q.push_back(50 + k);
    check_deps("R8 refused and drained");

    // R5 timeout skip
    do_reset();
    d0 = drop_cnt; l0 = lost_cnt;
    send1(0, 20, 1, 70);
    n = 0;
    while (!out_valid && n < 300) begin
      @(negedge clk);
      n++;
    end
    check(n >= TMO && n <= TMO + 2, "R5 timeout slot", n, TMO + 1);
    check(loss_skip == 1'b1, "R5 loss pulse", loss_skip, 1);
    check(out_tag == 8'd70, "R5 released", out_tag, 70);
    repeat (2) @(negedge clk);
    // R7 late copy is stale
    send1(0, 20, 0, 71);
    @(negedge clk);
    check(stale_drop == 1'b1, "R7 drop pulse", stale_drop, 1);
    check(!out_valid, "R7 nothing offered", out_valid, 0);
    send1(0, 20, 2, 72);
    repeat (3) @(negedge clk);
    exp_q = '{70, 72};
    check_deps("R7 table intact");
    check(drop_cnt - d0 == 1, "R7 one drop", drop_cnt - d0, 1);

    // R10 held cell goes stale after a skip
    d0 = drop_cnt; l0 = lost_cnt;
    send1(0, 30, 5, 80);
    send1(0, 30, 2, 81);
    repeat (2 * TMO + 20) @(negedge clk);
    exp_q = '{80};
    check_deps("R10 only skipped cell leaves");
    check(lost_cnt - l0 == 1, "R5 one loss", lost_cnt - l0, 1);
    check(drop_cnt - d0 == 1, "R10 stale timed out", drop_cnt - d0, 1);

    // random phase
    do_reset();
    for (int s = 0; s < 4; s++)
      for (int c = 0; c < 64; c++) begin bexp[s][c] = 0; gctr[s][c] = 0; end
    for (int i = 0; i < NR; i++) begin
      int st;
      g_src[i] = int'($urandom % 4);
      g_use[i] = int'($urandom % 15) + 1;
      st = int'($urandom % 8);
      for (int k = 0; k < 4; k++) begin
        g_idx[i][k] = (st + k) % 8;
        if (g_use[i][k] != 0) begin
          g_seq[i][k] = gctr[g_src[i]][g_idx[i][k]];
          gctr[g_src[i]][g_idx[i][k]]++;
        end else g_seq[i][k] = int'($urandom % 1024);
      end
    end
    d0 = drop_cnt; l0 = lost_cnt;
    rnd_mode = 1'b1;
    for (int g = 0; g < NR / 4; g++) begin
      int ord[4];
      int a, b, t;
      for (int j = 0; j < 4; j++) ord[j] = g * 4 + j;
      a = int'($urandom % 4); b = int'($urandom % 4);
      t = ord[a]; ord[a] = ord[b]; ord[b] = t;
      for (int j = 0; j < 4; j++) begin
        int c;
        c = ord[j];
        send(g_src[c], g_use[c], g_idx[c][0], g_idx[c][1], g_idx[c][2], g_idx[c][3],
             g_seq[c][0], g_seq[c][1], g_seq[c][2], g_seq[c][3], c);
      end
    end
    n = 0;
    while (dep_q.size() < NR && n < 3000) begin
      @(negedge clk);
      n++;
    end
    rnd_mode = 1'b0;
    set_ready(1'b1);
    check(dep_q.size() == NR, "R2 random all released", dep_q.size(), NR);
    check(drop_cnt == d0 && lost_cnt == l0, "R7 random no drops", drop_cnt - d0, 0);

    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule